// File: doc/BRIEF.md
# Ternary Rule Table with Stepwise Search Engine

This block holds a table of ternary classification rules. Each rule is eight 32-bit key words, eight 32-bit mask words, and one 32-bit action word kept in a separate array. A host reaches all of it through a small word-addressed register window. The window holds a command register and a set of holding registers for the key words, the mask words and the action word. To move one entry between the holding registers and the table, the host loads the holding registers if needed, writes a command, and then polls the command register until its start bit drops.

A search command scans the table from a chosen entry upward. It stops on every entry that has a non-zero valid field and is not entry 0. At each stop it copies that entry into the holding registers, raises a hit flag and shows the entry number in the address field. The engine then waits until the host reads the last key word, which releases it to continue. The start bit stays set for the whole scan and drops only after the last entry. A table-reset command invalidates every entry in one step.

Top module: `tcam_tbl`

## Requirements
- R1: Word map of the register window: 0 is the command register, 1..8 are key words 0..7, 9..16 are mask words 0..7, and 17 is the action word. Command register fields: bit 0 start, bits [2:1] operation (0 read, 1 write, 2 search, 3 none), bits [4:3] array select (0 rule table, 1 action array, 2 meter, 3 none), bit 5 hit, bit 6 table reset, bits [15:8] entry number. All other bits read as zero. After reset, the command register and all holding registers read zero.
- R2: A write command with array select 0 stores all key and mask holding words into the addressed entry. Key word 0 bits [1:0] become the entry's valid field. The start bit reads 1 for exactly one cycle after the command and then 0.
- R3: A read command with array select 0 copies the addressed entry into the key and mask holding registers within the same one-cycle busy window.
- R4: With array select 1, a read or write moves only the action word of the addressed entry. The key and mask holding registers are left unchanged.
- R5: With array select 2 (meter), a read or write completes in one busy cycle and changes no holding register and no entry.
- R6: A command-register write is ignored while the start bit or the reset bit is set. Operation, array select and entry number keep their values.
- R7: A search starts at the given entry. While no hit is pending, the entry number advances by one each cycle and the start bit stays 1.
- R8: On a hit, the hit bit rises and the entry's key, mask and action words appear in the holding registers. The entry number holds steady until the host reads key word 7 (register 8). The scan then moves to the next entry.
- R9: An entry whose valid field is 00, and entry 0 in every case, never produces a hit.
- R10: After the last entry (255) the start bit clears, and the entry number reads 255.
- R11: A table reset sets the reset bit for exactly one cycle and clears every entry's valid field. All other stored key and mask bits are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (side effect on key word 7 during a search hit) |
| reg_addr | input | 5 | Register word number |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
On every cycle, the bound checker verifies these rules: single transfers finish one cycle after they start; command writes are ignored while the block is busy; the scan steps forward exactly one entry per cycle unless it stops on a hit; a hit holds its entry number until released; entry 0 is never reported; a scan ends at the last entry; and the reset bit is a one-cycle pulse. What the bench alone can show is the content of the transfers and the hits. This covers round trips of key, mask and action words, the order of hits for different starting entries, the skipping of invalid entries, and the fact that a table reset keeps non-valid key bits. The bench shows these by comparing against its own behavioural model and its expected hit lists.

// File: rtl/tcam_tbl_pkg.sv
`timescale 1ns/1ps
package tcam_tbl_pkg;
   typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_SRCH = 2'd2, OP_NONE = 2'd3} op_e;
   typedef enum logic [1:0] {RS_RULE = 2'd0, RS_ACT = 2'd1, RS_METER = 2'd2, RS_NONE = 2'd3} rsel_e;
   typedef enum logic [2:0] {ST_IDLE, ST_XFER, ST_SCAN, ST_HOLD, ST_CLR} st_e;
   localparam int B_START = 0;
   localparam int B_OP    = 1;
   localparam int B_RS    = 3;
   localparam int B_HIT   = 5;
   localparam int B_TRST  = 6;
   localparam int B_ADDR  = 8;
endpackage

// File: rtl/tcam_tbl_store.sv
`timescale 1ns/1ps
module tcam_tbl_store #(
   parameter int DEPTH = 256,
   parameter int KW    = 8,
   parameter int DW    = 32,
   parameter int AW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    idx,
   input  logic             we_rule,
   input  logic             we_act,
   input  logic             clr_all,
   input  logic [KW*DW-1:0] wr_key,
   input  logic [KW*DW-1:0] wr_mask,
   input  logic [DW-1:0]    wr_act,
   output logic [KW*DW-1:0] rd_key,
   output logic [KW*DW-1:0] rd_mask,
   output logic [DW-1:0]    rd_act,
   output logic [1:0]       rd_vld
);
   logic [KW*DW-1:0] key_mem  [DEPTH];
   logic [KW*DW-1:0] mask_mem [DEPTH];
   logic [DW-1:0]    act_mem  [DEPTH];
   logic [1:0]       vld_q    [DEPTH];

   always_ff @(posedge clk) begin
      if (we_rule) begin
         key_mem[idx]  <= wr_key;
         mask_mem[idx] <= wr_mask;
      end
      if (we_act) act_mem[idx] <= wr_act;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) vld_q[i] <= 2'b00;
      end else if (clr_all) begin
         for (int i = 0; i < DEPTH; i++) vld_q[i] <= 2'b00;
      end else if (we_rule) begin
         vld_q[idx] <= wr_key[1:0];
      end
   end

   assign rd_vld  = vld_q[idx];
   assign rd_key  = {key_mem[idx][KW*DW-1:2], vld_q[idx]};
   assign rd_mask = mask_mem[idx];
   assign rd_act  = act_mem[idx];
endmodule

// File: rtl/tcam_tbl_ctrl.sv
`timescale 1ns/1ps
module tcam_tbl_ctrl
   import tcam_tbl_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_we,
   input  logic          w_start,
   input  logic          w_trst,
   input  logic [1:0]    w_op,
   input  logic [1:0]    w_rs,
   input  logic [AW-1:0] w_addr,
   input  logic          rel_rd,
   input  logic [1:0]    ent_vld,
   output logic          start,
   output logic          trst,
   output logic          hit,
   output logic [1:0]    op,
   output logic [1:0]    rsel,
   output logic [AW-1:0] addr,
   output logic          ld_rule,
   output logic          ld_act,
   output logic          st_rule,
   output logic          st_act,
   output logic          clr_all
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   st_e     st_q;
   op_e     op_q;
   rsel_e   rs_q;
   logic [AW-1:0] addr_q;
   logic    hit_now;

   assign hit_now = (st_q == ST_SCAN) && (ent_vld != 2'b00) && (addr_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         op_q   <= OP_RD;
         rs_q   <= RS_RULE;
         addr_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (cmd_we) begin
               op_q   <= op_e'(w_op);
               rs_q   <= rsel_e'(w_rs);
               addr_q <= w_addr;
               if (w_trst)       st_q <= ST_CLR;
               else if (w_start) st_q <= (op_e'(w_op) == OP_SRCH) ? ST_SCAN : ST_XFER;
            end
            ST_XFER, ST_CLR: st_q <= ST_IDLE;
            ST_SCAN: begin
               if (hit_now)              st_q <= ST_HOLD;
               else if (addr_q == LAST)  st_q <= ST_IDLE;
               else                      addr_q <= addr_q + 1'b1;
            end
            ST_HOLD: if (rel_rd) begin
               if (addr_q == LAST) st_q <= ST_IDLE;
               else begin
                  addr_q <= addr_q + 1'b1;
                  st_q   <= ST_SCAN;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign start   = (st_q == ST_XFER) || (st_q == ST_SCAN) || (st_q == ST_HOLD);
   assign trst    = (st_q == ST_CLR);
   assign hit     = (st_q == ST_HOLD);
   assign op      = op_q;
   assign rsel    = rs_q;
   assign addr    = addr_q;
   assign ld_rule = ((st_q == ST_XFER) && (op_q == OP_RD) && (rs_q == RS_RULE)) || hit_now;
   assign ld_act  = ((st_q == ST_XFER) && (op_q == OP_RD) && (rs_q == RS_ACT)) || hit_now;
   assign st_rule = (st_q == ST_XFER) && (op_q == OP_WR) && (rs_q == RS_RULE);
   assign st_act  = (st_q == ST_XFER) && (op_q == OP_WR) && (rs_q == RS_ACT);
   assign clr_all = (st_q == ST_CLR);
endmodule

// File: rtl/tcam_tbl.sv
`timescale 1ns/1ps
module tcam_tbl
   import tcam_tbl_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int KW    = 8,
   parameter int DW    = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int NREG = 2 * KW + 2,
   localparam int RAW  = $clog2(NREG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_wr_en,
   input  logic           reg_rd_en,
   input  logic [RAW-1:0] reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   output logic [DW-1:0]  reg_rdata
);
   localparam int A_ACT = 2 * KW + 1;

   if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DW < B_ADDR + AW) begin : g_bad_width
      $error("DW too narrow for the command register");
   end
   if (KW < 1) begin : g_bad_kw
      $error("KW must be at least 1");
   end

   logic c_start, c_trst, c_hit;
   logic [1:0] c_op, c_rs;
   logic [AW-1:0] c_addr;
   logic ld_rule, ld_act, st_rule, st_act, clr_all;
   logic cmd_we, rel_rd;
   logic [1:0] ent_vld;
   logic [KW*DW-1:0] rd_key, rd_mask, key_flat, mask_flat;
   logic [DW-1:0] rd_act;
   logic [DW-1:0] key_h  [KW];
   logic [DW-1:0] mask_h [KW];
   logic [DW-1:0] act_h;
   logic [KW-1:0] key_we, mask_we;

   assign cmd_we = reg_wr_en && (reg_addr == '0);
   assign rel_rd = reg_rd_en && (reg_addr == RAW'(KW));

   for (genvar w = 0; w < KW; w++) begin : g_word
      assign key_we[w]  = reg_wr_en && (reg_addr == RAW'(1 + w));
      assign mask_we[w] = reg_wr_en && (reg_addr == RAW'(1 + KW + w));
      assign key_flat[w*DW +: DW]  = key_h[w];
      assign mask_flat[w*DW +: DW] = mask_h[w];
   end

   tcam_tbl_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we),
      .w_start(reg_wdata[B_START]), .w_trst(reg_wdata[B_TRST]),
      .w_op(reg_wdata[B_OP +: 2]), .w_rs(reg_wdata[B_RS +: 2]),
      .w_addr(reg_wdata[B_ADDR +: AW]), .rel_rd(rel_rd), .ent_vld(ent_vld),
      .start(c_start), .trst(c_trst), .hit(c_hit), .op(c_op), .rsel(c_rs),
      .addr(c_addr), .ld_rule(ld_rule), .ld_act(ld_act), .st_rule(st_rule),
      .st_act(st_act), .clr_all(clr_all)
   );

   tcam_tbl_store #(.DEPTH(DEPTH), .KW(KW), .DW(DW), .AW(AW)) u_store (
      .clk(clk), .rst_n(rst_n), .idx(c_addr), .we_rule(st_rule), .we_act(st_act),
      .clr_all(clr_all), .wr_key(key_flat), .wr_mask(mask_flat), .wr_act(act_h),
      .rd_key(rd_key), .rd_mask(rd_mask), .rd_act(rd_act), .rd_vld(ent_vld)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < KW; w++) begin
            key_h[w]  <= '0;
            mask_h[w] <= '0;
         end
         act_h <= '0;
      end else begin
         for (int w = 0; w < KW; w++) begin
            if (ld_rule) begin
               key_h[w]  <= rd_key[w*DW +: DW];
               mask_h[w] <= rd_mask[w*DW +: DW];
            end else begin
               if (key_we[w])  key_h[w]  <= reg_wdata;
               if (mask_we[w]) mask_h[w] <= reg_wdata;
            end
         end
         if (ld_act) act_h <= rd_act;
         else if (reg_wr_en && reg_addr == RAW'(A_ACT)) act_h <= reg_wdata;
      end
   end

   always_comb begin
      int ra;
      ra = int'(reg_addr);
      reg_rdata = '0;
      if (ra == 0) begin
         reg_rdata[B_START]     = c_start;
         reg_rdata[B_OP +: 2]   = c_op;
         reg_rdata[B_RS +: 2]   = c_rs;
         reg_rdata[B_HIT]       = c_hit;
         reg_rdata[B_TRST]      = c_trst;
         reg_rdata[B_ADDR +: AW] = c_addr;
      end else if (ra <= KW) begin
         reg_rdata = key_h[ra - 1];
      end else if (ra <= 2 * KW) begin
         reg_rdata = mask_h[ra - KW - 1];
      end else if (ra == A_ACT) begin
         reg_rdata = act_h;
      end
   end
endmodule

// File: rtl/tcam_tbl_chk.sv
`timescale 1ns/1ps
module tcam_tbl_chk #(
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          trst,
   input logic          hit,
   input logic [1:0]    op,
   input logic [1:0]    rsel,
   input logic [AW-1:0] addr,
   input logic          cmd_we,
   input logic          rel_rd
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   assert_xfer_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(start) && op != 2'd2) |=> !start);

   assert_cmd_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((start || trst) && cmd_we) |=> ($stable(op) && $stable(rsel)));

   assert_scan_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 2'd2 && !hit && addr != LAST) |=>
         (start && ((hit && $stable(addr)) || addr == AW'($past(addr) + 1'b1))));

   assert_hit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !rel_rd) |=> (hit && $stable(addr)));

   assert_no_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (addr != '0));

   assert_scan_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(start) && op == 2'd2) |-> (addr == LAST));

   assert_trst_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      trst |=> (!trst && !start));
endmodule

bind tcam_tbl tcam_tbl_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(c_start), .trst(c_trst), .hit(c_hit),
   .op(c_op), .rsel(c_rs), .addr(c_addr), .cmd_we(cmd_we), .rel_rd(rel_rd)
);

// File: tb/tcam_tbl_test.sv
`timescale 1ns/1ps
module tcam_tbl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [4:0]  raddr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tcam_tbl uut (.clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
                 .reg_addr(raddr), .reg_wdata(wdata), .reg_rdata(rdata));

   // behavioural model of the command register and valid fields
   int       m_st = 0;  // 0 idle 1 xfer 2 scan 3 hold 4 clear
   int       m_op = 0, m_rs = 0, m_addr = 0;
   bit [1:0] m_vld [256];
   bit [1:0] m_k0lo = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_op = 0; m_rs = 0; m_addr = 0; m_k0lo = 0;
         foreach (m_vld[i]) m_vld[i] = 0;
      end else begin
         if (wr_en && raddr == 5'd1) m_k0lo = wdata[1:0];
         case (m_st)
            0: if (wr_en && raddr == 5'd0) begin
                  m_op = wdata[2:1]; m_rs = wdata[4:3]; m_addr = wdata[15:8];
                  if (wdata[6]) m_st = 4;
                  else if (wdata[0]) m_st = (m_op == 2) ? 2 : 1;
               end
            1: begin
                  if (m_rs == 0 && m_op == 1) m_vld[m_addr] = m_k0lo;
                  if (m_rs == 0 && m_op == 0) m_k0lo = m_vld[m_addr];
                  m_st = 0;
               end
            2: if (m_vld[m_addr] != 0 && m_addr != 0) begin
                  m_st = 3; m_k0lo = m_vld[m_addr];
               end else if (m_addr == 255) m_st = 0;
               else m_addr++;
            3: if (rd_en && raddr == 5'd8) begin
                  if (m_addr == 255) m_st = 0;
                  else begin m_addr++; m_st = 2; end
               end
            4: begin foreach (m_vld[i]) m_vld[i] = 0; m_st = 0; end
            default: m_st = 0;
         endcase
      end
   end

   function automatic logic [31:0] m_cmd();
      logic [31:0] v;
      v = '0;
      v[0] = (m_st == 1 || m_st == 2 || m_st == 3);
      v[2:1] = 2'(m_op); v[4:3] = 2'(m_rs);
      v[5] = (m_st == 3); v[6] = (m_st == 4);
      v[15:8] = 8'(m_addr);
      return v;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R7: per-cycle comparison of the command register with the model
   always @(negedge clk) if (rst_n && !done && raddr == 5'd0) chk("R7 cmd model", rdata, m_cmd());

   task automatic reg_write(logic [4:0] a, logic [31:0] d);
      @(posedge clk); #1; wr_en = 1; raddr = a; wdata = d;
      @(posedge clk); #1; wr_en = 0; raddr = 0;
   endtask

   task automatic reg_read(logic [4:0] a, output logic [31:0] d);
      @(posedge clk); #1; raddr = a; rd_en = 1; #1 d = rdata;
      @(posedge clk); #1; rd_en = 0; raddr = 0;
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      for (int n = 0; n < 2000; n++) begin
         reg_read(0, d);
         if (!d[0] && !d[6]) return;
      end
   endtask

   function automatic logic [31:0] kval(int idx, int w, bit [1:0] v);
      logic [31:0] k;
      k = {8'(idx), 8'(w), 16'hC0D0};
      if (w == 0) k = k | {28'd0, 2'(idx), v};
      return k;
   endfunction

   task automatic put_entry(int idx, bit [1:0] v);
      for (int w = 0; w < 8; w++) begin
         reg_write(5'(1 + w), kval(idx, w, v));
         reg_write(5'(9 + w), ~kval(idx, w, v));
      end
      reg_write(0, 32'h1 | (32'd1 << 1) | (32'(idx) << 8));
      wait_idle();
   endtask

   task automatic run_search(int from, int exp_q[$], string tag);
      logic [31:0] d;
      reg_write(0, 32'h1 | (32'd2 << 1) | (32'(from) << 8));
      for (int n = 0; n < 3000; n++) begin
         reg_read(0, d);
         if (d[5]) begin
            int e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
            chk("R8 hit entry", {24'd0, d[15:8]}, 32'(e));
            reg_read(2, d); chk("R8 hit key word 1", d, kval(e, 1, 0));
            reg_read(16, d); chk("R8 hit mask word 7", d, ~kval(e, 7, 0));
            reg_read(8, d); chk("R8 hit key word 7 release", d, kval(e, 7, 0));
         end else if (!d[0]) break;
      end
      chk({"R9 missing hits ", tag}, 32'(exp_q.size()), 0);
      reg_read(0, d);
      chk("R10 end entry and start clear", {d[15:8], 7'd0, d[0]}, {8'hFF, 8'h00});
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      reg_read(0, d);  chk("R1 cmd after reset", d, 0);
      reg_read(1, d);  chk("R1 key0 after reset", d, 0);
      reg_read(17, d); chk("R1 action after reset", d, 0);

      // R2 table writes
      put_entry(0, 2'b01);
      put_entry(5, 2'b01);
      put_entry(7, 2'b00);
      put_entry(9, 2'b10);
      put_entry(200, 2'b11);
      put_entry(255, 2'b01);

      // R3 read back entry 9 after clobbering holding registers
      reg_write(2, 32'h0);
      reg_write(0, 32'h1 | (32'(9) << 8));
      wait_idle();
      for (int w = 0; w < 8; w++) begin
         reg_read(5'(1 + w), d); chk("R3 key readback", d, kval(9, w, 2'b10));
         reg_read(5'(9 + w), d); chk("R3 mask readback", d, ~kval(9, w, 2'b10));
      end

      // R4 action array transfers
      reg_write(17, 32'hA5A5_0009);
      reg_write(0, 32'h1 | (32'd1 << 1) | (32'd1 << 3) | (32'(9) << 8));
      wait_idle();
      reg_write(17, 32'h0);
      reg_write(2, 32'hDEAD_BEEF);
      reg_write(0, 32'h1 | (32'd1 << 3) | (32'(9) << 8));
      wait_idle();
      reg_read(17, d); chk("R4 action readback", d, 32'hA5A5_0009);
      reg_read(2, d);  chk("R4 key untouched", d, 32'hDEAD_BEEF);

      // R5 meter select moves nothing
      reg_write(17, 32'h1234_5678);
      reg_write(0, 32'h1 | (32'd2 << 3) | (32'(9) << 8));
      wait_idle();
      reg_read(17, d); chk("R5 action unchanged", d, 32'h1234_5678);
      reg_read(2, d);  chk("R5 key unchanged", d, 32'hDEAD_BEEF);

      // R6 command ignored while a search runs, then R7/R8/R9/R10 search
      begin
         int q[$];
         reg_write(0, 32'h1 | (32'd2 << 1) | (32'(1) << 8));
         reg_write(0, 32'h1 | (32'd3 << 3) | (32'(9) << 8));
         reg_read(0, d);
         chk("R6 op kept during search", {30'd0, d[2:1]}, 32'd2);
         chk("R6 rsel kept during search", {30'd0, d[4:3]}, 32'd0);
         q = '{5, 9, 200, 255};
         for (int n = 0; n < 3000; n++) begin
            if (d[5]) begin
               int e;
               e = (q.size() > 0) ? q.pop_front() : -1;
               chk("R8 hit entry (busy case)", {24'd0, d[15:8]}, 32'(e));
               reg_read(8, d);
            end else if (!d[0]) break;
            reg_read(0, d);
         end
         chk("R9 missing hits first scan", 32'(q.size()), 0);
      end
      run_search(1, '{5, 9, 200, 255}, "from 1");
      run_search(10, '{200, 255}, "from 10");

      // R11 table reset
      reg_write(0, 32'h1 << 6);
      wait_idle();
      reg_write(0, 32'h1 | (32'(9) << 8));
      wait_idle();
      reg_read(1, d); chk("R11 valid cleared, slice kept", d, kval(9, 0, 2'b00));
      reg_read(3, d); chk("R11 key word 2 kept", d, kval(9, 2, 0));
      run_search(0, '{}, "after reset");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule